// File: doc/BRIEF.md
# Timer Event Flag Unit

A free-running up-counter with a set of compare channels and edge-triggered capture channels. Each channel has its own bit in an event flag register. A compare channel raises an event while the timer runs and the count equals the value programmed for that channel. A capture channel synchronises an external pin through two flops, detects the selected edge, and copies the live count into that channel's capture register. An event sets its flag only when its enable bit is on. The interrupt line is the OR of all flags.

Software uses a single-port register bus. Reads are combinational on the address. A write takes effect at the next rising edge. Software clears flags by writing ones. The flag logic gives a hardware set priority over every clear in the same cycle. A clear aimed at one bit therefore never drops an event that lands on another bit, or on the same bit, in that cycle. Software can stop the timer, reload it and restart it without disturbing the count it holds.

Register addresses (4-bit):
- 0: control; bit 0 is run.
- 1: flags.
- 2: flag enables.
- 3: count; readable, and a write loads it.
- 4: edge select.
- 8+i: compare value of channel i.
- 12+j: capture value of channel j, read only.

Top module: `evt_timer`

## Requirements
- R1: While run (address 0, bit 0) is 1, the count at address 3 rises by one per clock. It wraps from 2^CNT_W-1 to 0.
- R2: While run is 0, the count holds its value. Setting run again resumes counting from that held value. A write to address 3 loads the count.
- R3: When the timer runs and the count equals the compare value of channel i (address 8+i), flag bit i is set at the next edge, provided enable bit i (address 2) is 1. Bit 0 belongs to compare channel 0 and bit 1 to compare channel 1.
- R4: Capture channel j has flag bit N_MATCH+j, enable bit N_MATCH+j and edge select bit j at address 4 (0 means rising, 1 means falling). On the selected pin edge it latches into address 12+j the count present just before the third rising clock edge after the pin change. That value is two above the count at the change when the timer runs.
- R5: An event whose enable bit is 0 sets no flag. A capture still updates its capture register.
- R6: Writing 1 to a flag bit at address 1 clears it. Writing 0 leaves it unchanged.
- R7: A flag write that clears bit 0 in the same cycle as a compare channel 1 event leaves bit 1 set.
- R8: When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: A capture event in the same cycle as a flag write that clears all bits still sets its capture flag.
- R10: irq is 1 whenever any flag is set. It stays 1 until the last flag is cleared.
- R11: After reset the count, run, flags, enables, edge selects, compare and capture values are 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Read data for addr, combinational |
| cap_pin | input | N_CAP | Capture input pins |
| irq | output | 1 | OR of all flag bits |

## Verification
The bench lines up flag writes with the exact cycle in which the count equals a compare value. It does the same with the cycle in which a synchronised capture edge arrives.

A design that builds the next flag value as a plain write of the register, or that lets a clear override a set, loses the compare channel 1 flag or keeps the same-bit flag cleared. Both failures show up on the flag read that follows.

The bench checks the capture value against the count two cycles after the pin change. This exposes a synchroniser one flop too short or too long.

It also checks the following:
- The falling-edge select, which a design that ignores it would capture on the wrong transition.
- Disabled channels, whose flags a design that drops the enable gate would raise.
- The count wrap.
- Stop and restart, which a design that reset the count would fail.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int REG_AW   = 4;
  localparam int A_CTRL   = 0;
  localparam int A_FLAG   = 1;
  localparam int A_IEN    = 2;
  localparam int A_CNT    = 3;
  localparam int A_EDGE   = 4;
  localparam int A_MATCH0 = 8;
  localparam int A_CAP0   = 12;
  localparam int MAX_CH   = 4;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic go,
    input logic ld, input logic [CNT_W-1:0] ld_val);
    if (ld)      return ld_val;
    else if (go) return cur + 1'b1;
    else         return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, run, load, load_val);
  end

  // R1: one step per cycle while running
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R2: held while stopped
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/evt_capture_ch.sv
module evt_capture_ch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             fall_sel,
  input  logic [CNT_W-1:0] cnt,
  output logic             evt,
  output logic [CNT_W-1:0] cap_val
);
  logic sync1, sync2, sync_prev;
  logic rise_seen, fall_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      sync_prev <= 1'b0;
    end else begin
      sync1     <= pin;
      sync2     <= sync1;
      sync_prev <= sync2;
    end
  end

  assign rise_seen = sync2 & ~sync_prev;
  assign fall_seen = ~sync2 & sync_prev;
  assign evt       = fall_sel ? fall_seen : rise_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cap_val <= '0;
    else if (evt) cap_val <= cnt;
  end

  // R4: capture register takes the count seen with the edge
  p_capture_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cap_val == $past(cnt)));

  // R4: a detected edge lasts a single cycle
  p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/evt_flags.sv
module evt_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags,
  output logic          irq
);
  // Sets are applied after clears, so an arriving event always survives.
  function automatic logic [NF-1:0] next_flags(
    input logic [NF-1:0] cur, input logic [NF-1:0] s, input logic [NF-1:0] c);
    return (cur & ~c) | s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= next_flags(flags, set, clr);
  end

  assign irq = |flags;

  // R7, R8, R9: every requested set is visible next cycle, whatever the clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));

  // R6: cleared bits without a set go low
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0));

  // R10: the line can only drop after a clear
  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(clr) != '0));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 2,
  parameter int N_CAP   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [CNT_W-1:0]    wr_data,
  output logic [CNT_W-1:0]    rd_data,
  input  logic [N_CAP-1:0]    cap_pin,
  output logic                irq
);
  localparam int NF = N_MATCH + N_CAP;

  logic             run;
  logic [NF-1:0]    ien;
  logic [N_CAP-1:0] edge_cfg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] match_reg [N_MATCH];
  logic [CNT_W-1:0] cap_reg   [N_CAP];
  logic [N_MATCH-1:0] match_evt;
  logic [N_CAP-1:0]   cap_evt;
  logic [NF-1:0]    flag_set, flag_clr, flags;
  logic             cnt_load;
  int               a_int;

  assign a_int    = int'(addr);
  assign cnt_load = wr_en && (a_int == A_CNT);
  assign flag_clr = (wr_en && a_int == A_FLAG) ? wr_data[NF-1:0] : '0;
  assign flag_set = {cap_evt, match_evt} & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      ien      <= '0;
      edge_cfg <= '0;
    end else if (wr_en) begin
      if (a_int == A_CTRL) run      <= wr_data[0];
      if (a_int == A_IEN)  ien      <= wr_data[NF-1:0];
      if (a_int == A_EDGE) edge_cfg <= wr_data[N_CAP-1:0];
    end
  end

  evt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .load(cnt_load),
    .load_val(wr_data), .cnt(cnt));

  function automatic logic is_hit(input logic go, input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] m);
    return go && (c == m);
  endfunction

  for (genvar i = 0; i < N_MATCH; i++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_reg[i] <= '0;
      else if (wr_en && a_int == A_MATCH0 + i) match_reg[i] <= wr_data;
    end
    assign match_evt[i] = is_hit(run, cnt, match_reg[i]);
  end

  for (genvar j = 0; j < N_CAP; j++) begin : g_cap
    evt_capture_ch #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin[j]),
      .fall_sel(edge_sel_e'(edge_cfg[j]) == EDGE_FALL),
      .cnt(cnt), .evt(cap_evt[j]), .cap_val(cap_reg[j]));
  end

  evt_flags #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
    .flags(flags), .irq(irq));

  always_comb begin
    rd_data = '0;
    if (a_int == A_CTRL)      rd_data[0]       = run;
    else if (a_int == A_FLAG) rd_data[NF-1:0]  = flags;
    else if (a_int == A_IEN)  rd_data[NF-1:0]  = ien;
    else if (a_int == A_CNT)  rd_data          = cnt;
    else if (a_int == A_EDGE) rd_data[N_CAP-1:0] = edge_cfg;
    else begin
      for (int k = 0; k < N_MATCH; k++)
        if (a_int == A_MATCH0 + k) rd_data = match_reg[k];
      for (int k = 0; k < N_CAP; k++)
        if (a_int == A_CAP0 + k) rd_data = cap_reg[k];
    end
  end

  // R3: an enabled compare hit raises the interrupt line next cycle
  p_match_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt == match_reg[0]) && ien[0]) |=> irq);

  // R5: a disabled event alone cannot raise the line
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (flag_set == '0)) |=> !irq);

  initial begin
    assert (N_MATCH <= MAX_CH && N_CAP <= MAX_CH && NF <= CNT_W)
      else $error("evt_timer: channel counts exceed register map");
  end
endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int CW = 16;
  localparam logic [3:0] AD_CTRL = 4'd0, AD_FLAG = 4'd1, AD_IEN = 4'd2,
                         AD_CNT = 4'd3, AD_EDGE = 4'd4, AD_M0 = 4'd8,
                         AD_M1 = 4'd9, AD_C0 = 4'd12, AD_C1 = 4'd13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data;
  logic [1:0] cap_pin = '0;
  logic irq;
  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  evt_timer u_evt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cap_pin(cap_pin), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_now(input logic [3:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [CW-1:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic wait_cnt(input logic [CW-1:0] v);
    logic [CW-1:0] c;
    for (int k = 0; k < 70000; k++) begin
      rd(AD_CNT, c);
      if (c == v) break;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [CW-1:0] start, input logic [CW-1:0] en);
    wr(AD_CTRL, 16'd0);
    wr(AD_CNT, start);
    wr(AD_IEN, en);
    wr(AD_FLAG, 16'hFFFF);
  endtask

  task automatic t_reset;
    logic [CW-1:0] d;
    rd(AD_CNT, d);  chk("R11 count", d, 0);
    rd(AD_CTRL, d); chk("R11 run", d, 0);
    rd(AD_FLAG, d); chk("R11 flags", d, 0);
    rd(AD_IEN, d);  chk("R11 enables", d, 0);
    rd(AD_M1, d);   chk("R11 compare", d, 0);
    rd(AD_C0, d);   chk("R11 capture", d, 0);
    chk("R11 irq", irq, 0);
  endtask

  task automatic t_count;
    logic [CW-1:0] a, b;
    setup(16'd50, 16'd0);
    wr(AD_CTRL, 16'd1);
    rd(AD_CNT, a);
    repeat (4) @(negedge clk);
    rd(AD_CNT, b); chk("R1 step", b, a + 16'd4);
    wr(AD_CTRL, 16'd0);
    rd(AD_CNT, a);
    repeat (5) @(negedge clk);
    rd(AD_CNT, b); chk("R2 hold", b, a);
    wr(AD_CTRL, 16'd1);
    repeat (3) @(negedge clk);
    rd(AD_CNT, b); chk("R2 resume", b, a + 16'd3);
    setup(16'hFFFE, 16'd0);
    wr(AD_CTRL, 16'd1);
    repeat (3) @(negedge clk);
    rd(AD_CNT, b); chk("R1 wrap", b, 16'h0001);
  endtask

  task automatic t_match;
    logic [CW-1:0] d;
    setup(16'd100, 16'd1);
    wr(AD_M0, 16'd103);
    wr(AD_M1, 16'd900);
    wr(AD_CTRL, 16'd1);
    wait_cnt(16'd103);
    @(negedge clk);
    rd(AD_FLAG, d); chk("R3 match0 flag", d, 16'h1);
    chk("R10 irq set", irq, 1);
    wr(AD_FLAG, 16'h0);
    rd(AD_FLAG, d); chk("R6 zero write", d, 16'h1);
    wr(AD_FLAG, 16'h1);
    rd(AD_FLAG, d); chk("R6 clear", d, 16'h0);
    chk("R10 irq clear", irq, 0);
  endtask

  task automatic t_disabled;
    logic [CW-1:0] d;
    setup(16'd200, 16'd0);
    wr(AD_M0, 16'd202);
    wr(AD_CTRL, 16'd1);
    wait_cnt(16'd205);
    rd(AD_FLAG, d); chk("R5 disabled match", d, 16'h0);
    chk("R5 irq quiet", irq, 0);
  endtask

  task automatic t_coincide;
    logic [CW-1:0] d;
    setup(16'd300, 16'd3);
    wr(AD_M0, 16'd305);
    wr(AD_M1, 16'd310);
    wr(AD_CTRL, 16'd1);
    wait_cnt(16'd310);
    wr_now(AD_FLAG, 16'h1);
    rd(AD_FLAG, d); chk("R7 other bit kept", d, 16'h2);
    chk("R10 irq held", irq, 1);
    wr(AD_M0, 16'd330);
    wait_cnt(16'd330);
    wr_now(AD_FLAG, 16'h1);
    rd(AD_FLAG, d); chk("R8 same bit kept", d, 16'h3);
    wr(AD_FLAG, 16'h1);
    chk("R10 irq after partial clear", irq, 1);
    wr(AD_FLAG, 16'h2);
    chk("R10 irq after last clear", irq, 0);
  endtask

  task automatic t_capture;
    logic [CW-1:0] d, c0;
    setup(16'h1234, 16'hC);
    wr(AD_EDGE, 16'h2);
    @(negedge clk); cap_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(AD_C0, d); chk("R4 rising value", d, 16'h1234);
    rd(AD_FLAG, d); chk("R4 rising flag", d, 16'h4);
    wr(AD_FLAG, 16'hF);
    wr(AD_CNT, 16'h0777);
    cap_pin[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(AD_C1, d); chk("R4 falling ignores rise", d, 16'h0);
    cap_pin[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(AD_C1, d); chk("R4 falling value", d, 16'h0777);
    rd(AD_FLAG, d); chk("R4 falling flag", d, 16'h8);
    wr(AD_FLAG, 16'hF);
    cap_pin[0] = 1'b0;
    repeat (4) @(negedge clk);
    wr(AD_CTRL, 16'd1);
    rd(AD_CNT, c0);
    cap_pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_now(AD_FLAG, 16'hF);
    rd(AD_FLAG, d); chk("R9 capture during clear", d, 16'h4);
    rd(AD_C0, d); chk("R4 running value", d, c0 + 16'd2);
    wr(AD_CTRL, 16'd0);
    wr(AD_IEN, 16'h0);
    wr(AD_FLAG, 16'hF);
    wr(AD_CNT, 16'h0055);
    cap_pin[0] = 1'b0;
    repeat (3) @(negedge clk);
    cap_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(AD_C0, d); chk("R5 capture still latches", d, 16'h0055);
    rd(AD_FLAG, d); chk("R5 capture flag off", d, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_match();
    t_disabled();
    t_coincide();
    t_capture();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule